// File: doc/BRIEF.md
# Block-Mapped Flash Address Translator

This block turns logical page addresses into physical flash page locations for a storage layer that maps whole blocks. A logical address is cut into a virtual block number (upper bits) and a page offset (lower bits). A small on-chip table holds, for every virtual block, a primary physical block and an optional replacement physical block, together with a used bit per primary page, a fill pointer for the replacement block and the logical offset recorded at each programmed replacement page.

A write first tries the page at the same offset inside the primary block. If that page has already been programmed, the write goes to the next free page of the replacement block, which fills strictly in ascending order. Stale copies cannot be marked dead, so a read scans the replacement block from its newest programmed page downward and returns the first page whose recorded offset matches. If nothing matches, it falls back to the primary page. Missing physical blocks are requested from an external allocator, and the block stalls until one is granted. Requests are served one at a time.

The controller has five states. IDLE accepts a request (IDLE to DECIDE). DECIDE resolves the request and moves to ALLOC, SCAN or RESP. ALLOC holds the allocator request until a grant arrives (ALLOC to DECIDE). SCAN steps one replacement page per cycle (SCAN to RESP on a match or after page 0, otherwise it stays in SCAN). RESP presents the result for one cycle (RESP to IDLE).

Top module: `flash_blk_xlat`

## Requirements
- R1: With default parameters (8 pages per block, 16 virtual blocks), the page offset is `req_laddr[2:0]` and the virtual block is `req_laddr[6:3]`. For example, address 7'h4B selects virtual block 9, offset 3.
- R2: `req_ready` is high only when no request is in flight. Each accepted request (`req_valid` and `req_ready` both high at a clock edge) produces exactly one single-cycle `rsp_valid` pulse before `req_ready` rises again.
- R3: A write whose primary page at the offset is unused marks that page used and responds with `rsp_found`=1, `rsp_err`=0, `rsp_blk`=primary block and `rsp_page`=offset.
- R4: A write to a virtual block with no primary block raises `alloc_req` and holds it high until `alloc_gnt`. The granted `alloc_blk` becomes the primary block.
- R5: A write whose primary page is already used, in a virtual block with no replacement block, allocates a replacement block through the same handshake and lands on its page 0.
- R6: Each further write that falls back to the replacement block lands on the next page in ascending order. The page number equals the number of earlier fallback writes to that virtual block.
- R7: A fallback write to a full replacement block (all 8 pages programmed) responds with `rsp_err`=1 and `rsp_found`=0, and changes no mapping state.
- R8: A read returns the highest-numbered programmed replacement page whose recorded offset equals the requested offset, with `rsp_found`=1.
- R9: A read with no matching replacement page returns the primary block at the requested offset when that primary page is used.
- R10: A read of an offset that has never been written responds with `rsp_found`=0 and `rsp_err`=0. A read never raises `alloc_req`.
- R11: After reset, `req_ready`=1, `rsp_valid`=0 and `alloc_req`=0, and every virtual block is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_laddr | input | 7 | Logical page address |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_found | output | 1 | Physical location is valid |
| rsp_err | output | 1 | Replacement block full; the block must be merged |
| rsp_blk | output | 8 | Physical block number |
| rsp_page | output | 3 | Page inside the physical block |
| alloc_req | output | 1 | Request for a free physical block |
| alloc_gnt | input | 1 | Allocator grant strobe |
| alloc_blk | input | 8 | Granted physical block number |

## Verification
The bench drives one offset repeatedly until its replacement block is full. A design that did not fill pages in ascending order would return wrong page numbers. A design that let the failing write advance the fill pointer would corrupt the following read, which must still return page 7. Reads after several rewrites of the same offset, mixed with writes to other offsets, catch a scan that returns the oldest copy or stops at the first page. Reads of never-written offsets catch a design that reports a stale primary page or requests a block on a read. A randomized allocator grant delay exposes a design that drops `alloc_req` early or misassigns the granted block between the primary and replacement slots.

// File: rtl/flt_pkg.sv
package flt_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_DECIDE,
        S_ALLOC,
        S_SCAN,
        S_RESP
    } fsm_state_t;

    typedef enum logic {
        TGT_PRIM,
        TGT_REP
    } alloc_tgt_t;
endpackage

// File: rtl/flt_map_table.sv
module flt_map_table #(
    parameter int PAGES    = 8,
    parameter int NUM_VBLK = 16,
    parameter int BLK_W    = 8,
    localparam int PG_W    = $clog2(PAGES),
    localparam int VB_W    = $clog2(NUM_VBLK),
    localparam int WP_W    = PG_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VB_W-1:0]  rd_vbn,
    input  logic [PG_W-1:0]  rd_idx,
    output logic             prim_ok,
    output logic [BLK_W-1:0] prim_blk,
    output logic [PAGES-1:0] prim_used,
    output logic             rep_ok,
    output logic [BLK_W-1:0] rep_blk,
    output logic [WP_W-1:0]  rep_wp,
    output logic [PG_W-1:0]  rep_off_at,
    input  logic             set_prim,
    input  logic             set_rep,
    input  logic [BLK_W-1:0] new_blk,
    input  logic             mark_used,
    input  logic [PG_W-1:0]  use_off,
    input  logic             rep_append,
    input  logic [PG_W-1:0]  append_off
);
    logic             prim_ok_q  [NUM_VBLK];
    logic [BLK_W-1:0] prim_blk_q [NUM_VBLK];
    logic [PAGES-1:0] used_q     [NUM_VBLK];
    logic             rep_ok_q   [NUM_VBLK];
    logic [BLK_W-1:0] rep_blk_q  [NUM_VBLK];
    logic [WP_W-1:0]  wp_q       [NUM_VBLK];
    logic [PG_W-1:0]  roff_q     [NUM_VBLK][PAGES];

    assign prim_ok    = prim_ok_q[rd_vbn];
    assign prim_blk   = prim_blk_q[rd_vbn];
    assign prim_used  = used_q[rd_vbn];
    assign rep_ok     = rep_ok_q[rd_vbn];
    assign rep_blk    = rep_blk_q[rd_vbn];
    assign rep_wp     = wp_q[rd_vbn];
    assign rep_off_at = roff_q[rd_vbn][rd_idx];

    // state bits that must clear on reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int v = 0; v < NUM_VBLK; v++) begin
                prim_ok_q[v] <= 1'b0;
                used_q[v]    <= '0;
                rep_ok_q[v]  <= 1'b0;
                wp_q[v]      <= '0;
            end
        end else begin
            if (set_prim)   prim_ok_q[rd_vbn] <= 1'b1;
            if (set_rep)    rep_ok_q[rd_vbn]  <= 1'b1;
            if (mark_used)  used_q[rd_vbn][use_off] <= 1'b1;
            if (rep_append) wp_q[rd_vbn] <= wp_q[rd_vbn] + WP_W'(1);
        end
    end

    // payload storage, qualified by the bits above
    always_ff @(posedge clk) begin
        if (set_prim)   prim_blk_q[rd_vbn] <= new_blk;
        if (set_rep)    rep_blk_q[rd_vbn]  <= new_blk;
        if (rep_append) roff_q[rd_vbn][wp_q[rd_vbn][PG_W-1:0]] <= append_off;
    end

    // R6: appending only into a block that still has a free page
    assert_seq_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rep_append |-> (rep_wp < WP_W'(PAGES)));
    // R3: a primary page is never programmed twice
    assert_no_reprogram_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mark_used |-> !prim_used[use_off]);
    // R6: the fill pointer advances by one per append
    assert_wp_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rep_append |=> (rep_wp == $past(rep_wp) + WP_W'(1)));
endmodule

// File: rtl/flt_ctrl_fsm.sv
module flt_ctrl_fsm
    import flt_pkg::*;
#(
    parameter int PAGES    = 8,
    parameter int NUM_VBLK = 16,
    parameter int BLK_W    = 8,
    localparam int PG_W    = $clog2(PAGES),
    localparam int VB_W    = $clog2(NUM_VBLK),
    localparam int WP_W    = PG_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [VB_W-1:0]  req_vbn,
    input  logic [PG_W-1:0]  req_off,
    output logic             req_ready,
    output logic [VB_W-1:0]  cur_vbn,
    output logic [PG_W-1:0]  cur_off,
    output logic [PG_W-1:0]  scan_idx,
    input  logic             prim_ok,
    input  logic [BLK_W-1:0] prim_blk,
    input  logic [PAGES-1:0] prim_used,
    input  logic             rep_ok,
    input  logic [BLK_W-1:0] rep_blk,
    input  logic [WP_W-1:0]  rep_wp,
    input  logic [PG_W-1:0]  rep_off_at,
    output logic             set_prim,
    output logic             set_rep,
    output logic             mark_used,
    output logic             rep_append,
    output logic             alloc_req,
    input  logic             alloc_gnt,
    output logic             rsp_valid,
    output logic             rsp_found,
    output logic             rsp_err,
    output logic [BLK_W-1:0] rsp_blk,
    output logic [PG_W-1:0]  rsp_page
);
    fsm_state_t state_q, state_d;
    alloc_tgt_t tgt_q, tgt_d;
    logic       tgt_load;
    logic       wr_q;
    logic [VB_W-1:0]  vbn_q;
    logic [PG_W-1:0]  off_q, idx_q, idx_d;
    logic             idx_load;
    logic             res_load, res_found, res_err;
    logic [BLK_W-1:0] res_blk, rsp_blk_q;
    logic [PG_W-1:0]  res_page, rsp_page_q;
    logic             rsp_found_q, rsp_err_q;
    logic             prim_hit;

    assign cur_vbn  = vbn_q;
    assign cur_off  = off_q;
    assign scan_idx = idx_q;
    assign prim_hit = prim_ok && prim_used[off_q];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d    = state_q;
        req_ready  = 1'b0;
        alloc_req  = 1'b0;
        set_prim   = 1'b0;
        set_rep    = 1'b0;
        mark_used  = 1'b0;
        rep_append = 1'b0;
        tgt_d      = tgt_q;
        tgt_load   = 1'b0;
        idx_d      = idx_q;
        idx_load   = 1'b0;
        res_load   = 1'b0;
        res_found  = 1'b0;
        res_err    = 1'b0;
        res_blk    = '0;
        res_page   = '0;
        unique case (state_q)
            S_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) state_d = S_DECIDE;
            end
            S_DECIDE: begin
                if (wr_q) begin
                    if (!prim_ok) begin
                        tgt_d = TGT_PRIM; tgt_load = 1'b1; state_d = S_ALLOC;
                    end else if (!prim_used[off_q]) begin
                        mark_used = 1'b1; res_load = 1'b1; res_found = 1'b1;
                        res_blk = prim_blk; res_page = off_q; state_d = S_RESP;
                    end else if (!rep_ok) begin
                        tgt_d = TGT_REP; tgt_load = 1'b1; state_d = S_ALLOC;
                    end else if (rep_wp == WP_W'(PAGES)) begin
                        res_load = 1'b1; res_err = 1'b1; state_d = S_RESP;
                    end else begin
                        rep_append = 1'b1; res_load = 1'b1; res_found = 1'b1;
                        res_blk = rep_blk; res_page = rep_wp[PG_W-1:0];
                        state_d = S_RESP;
                    end
                end else if (rep_ok && rep_wp != '0) begin
                    idx_d = PG_W'(rep_wp - WP_W'(1)); idx_load = 1'b1;
                    state_d = S_SCAN;
                end else begin
                    res_load = 1'b1; res_found = prim_hit;
                    res_blk = prim_hit ? prim_blk : '0;
                    res_page = prim_hit ? off_q : '0;
                    state_d = S_RESP;
                end
            end
            S_ALLOC: begin
                alloc_req = 1'b1;
                if (alloc_gnt) begin
                    set_prim = (tgt_q == TGT_PRIM);
                    set_rep  = (tgt_q == TGT_REP);
                    state_d  = S_DECIDE;
                end
            end
            S_SCAN: begin
                if (rep_off_at == off_q) begin
                    res_load = 1'b1; res_found = 1'b1;
                    res_blk = rep_blk; res_page = idx_q; state_d = S_RESP;
                end else if (idx_q == '0) begin
                    res_load = 1'b1; res_found = prim_hit;
                    res_blk = prim_hit ? prim_blk : '0;
                    res_page = prim_hit ? off_q : '0;
                    state_d = S_RESP;
                end else begin
                    idx_d = idx_q - PG_W'(1); idx_load = 1'b1;
                end
            end
            S_RESP:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // request capture, scan index and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= 1'b0; vbn_q <= '0; off_q <= '0; idx_q <= '0;
            tgt_q <= TGT_PRIM;
            rsp_found_q <= 1'b0; rsp_err_q <= 1'b0;
            rsp_blk_q <= '0; rsp_page_q <= '0;
        end else begin
            if (state_q == S_IDLE && req_valid) begin
                wr_q <= req_write; vbn_q <= req_vbn; off_q <= req_off;
            end
            if (tgt_load) tgt_q <= tgt_d;
            if (idx_load) idx_q <= idx_d;
            if (res_load) begin
                rsp_found_q <= res_found; rsp_err_q <= res_err;
                rsp_blk_q <= res_blk; rsp_page_q <= res_page;
            end
        end
    end

    assign rsp_valid = (state_q == S_RESP);
    assign rsp_found = rsp_found_q;
    assign rsp_err   = rsp_err_q;
    assign rsp_blk   = rsp_blk_q;
    assign rsp_page  = rsp_page_q;

    assert_single_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    assert_one_in_flight_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    assert_alloc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && !alloc_gnt) |=> alloc_req);
    assert_err_not_found_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> !rsp_found);
    assert_read_no_alloc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req |-> wr_q);
endmodule

// File: rtl/flash_blk_xlat.sv
module flash_blk_xlat #(
    parameter int PAGES    = 8,
    parameter int NUM_VBLK = 16,
    parameter int BLK_W    = 8,
    localparam int PG_W    = $clog2(PAGES),
    localparam int VB_W    = $clog2(NUM_VBLK),
    localparam int LA_W    = VB_W + PG_W,
    localparam int WP_W    = PG_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [LA_W-1:0]  req_laddr,
    output logic             rsp_valid,
    output logic             rsp_found,
    output logic             rsp_err,
    output logic [BLK_W-1:0] rsp_blk,
    output logic [PG_W-1:0]  rsp_page,
    output logic             alloc_req,
    input  logic             alloc_gnt,
    input  logic [BLK_W-1:0] alloc_blk
);
    // R1: power-of-two pages per block makes the split a bit slice
    logic [VB_W-1:0] req_vbn, cur_vbn;
    logic [PG_W-1:0] req_off, cur_off, scan_idx;
    assign req_vbn = req_laddr[LA_W-1:PG_W];
    assign req_off = req_laddr[PG_W-1:0];

    logic             prim_ok, rep_ok;
    logic [BLK_W-1:0] prim_blk, rep_blk;
    logic [PAGES-1:0] prim_used;
    logic [WP_W-1:0]  rep_wp;
    logic [PG_W-1:0]  rep_off_at;
    logic             set_prim, set_rep, mark_used, rep_append;

    flt_map_table #(.PAGES(PAGES), .NUM_VBLK(NUM_VBLK), .BLK_W(BLK_W)) i_table (
        .clk(clk), .rst_n(rst_n),
        .rd_vbn(cur_vbn), .rd_idx(scan_idx),
        .prim_ok(prim_ok), .prim_blk(prim_blk), .prim_used(prim_used),
        .rep_ok(rep_ok), .rep_blk(rep_blk), .rep_wp(rep_wp), .rep_off_at(rep_off_at),
        .set_prim(set_prim), .set_rep(set_rep), .new_blk(alloc_blk),
        .mark_used(mark_used), .use_off(cur_off),
        .rep_append(rep_append), .append_off(cur_off)
    );

    flt_ctrl_fsm #(.PAGES(PAGES), .NUM_VBLK(NUM_VBLK), .BLK_W(BLK_W)) i_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_vbn(req_vbn), .req_off(req_off), .req_ready(req_ready),
        .cur_vbn(cur_vbn), .cur_off(cur_off), .scan_idx(scan_idx),
        .prim_ok(prim_ok), .prim_blk(prim_blk), .prim_used(prim_used),
        .rep_ok(rep_ok), .rep_blk(rep_blk), .rep_wp(rep_wp), .rep_off_at(rep_off_at),
        .set_prim(set_prim), .set_rep(set_rep), .mark_used(mark_used),
        .rep_append(rep_append),
        .alloc_req(alloc_req), .alloc_gnt(alloc_gnt),
        .rsp_valid(rsp_valid), .rsp_found(rsp_found), .rsp_err(rsp_err),
        .rsp_blk(rsp_blk), .rsp_page(rsp_page)
    );
endmodule

// File: tb/test_flash_blk_xlat.sv
module test_flash_blk_xlat;
    localparam int P = 8;
    localparam int NV = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0;
    logic [6:0] req_laddr = '0;
    logic       req_ready, rsp_valid, rsp_found, rsp_err, alloc_req;
    logic [7:0] rsp_blk;
    logic [2:0] rsp_page;
    logic       alloc_gnt = 1'b0;
    logic [7:0] alloc_blk = '0;

    int checks = 0, errors = 0, cycles = 0;

    flash_blk_xlat i_flash_blk_xlat (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_laddr(req_laddr), .rsp_valid(rsp_valid),
        .rsp_found(rsp_found), .rsp_err(rsp_err), .rsp_blk(rsp_blk),
        .rsp_page(rsp_page), .alloc_req(alloc_req), .alloc_gnt(alloc_gnt),
        .alloc_blk(alloc_blk)
    );

    always #10 clk = ~clk;

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: got cycles=%0d expected < 150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // allocator with random grant delay, blocks handed out in order
    int unsigned gnt_next = 8'd40, gnt_dly = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (alloc_gnt) alloc_gnt = 1'b0;
            else if (alloc_req) begin
                if (gnt_dly == 0) begin
                    alloc_gnt = 1'b1; alloc_blk = 8'(gnt_next); gnt_next++;
                    gnt_dly = $urandom % 4;
                end else gnt_dly--;
            end
        end
    end

    // reference model
    bit          m_pv [NV];
    int unsigned m_pb [NV];
    bit [P-1:0]  m_used [NV];
    bit          m_rv [NV];
    int unsigned m_rb [NV];
    int unsigned m_wp [NV];
    int unsigned m_ro [NV][P];
    int unsigned m_next = 40;

    task automatic model(input bit w, input int unsigned a,
                         output bit f, output bit e, output int unsigned b, output int unsigned pg);
        int unsigned v = a / P;
        int unsigned o = a % P;
        f = 0; e = 0; b = 0; pg = 0;
        if (w) begin
            if (!m_pv[v]) begin m_pv[v] = 1; m_pb[v] = m_next; m_next++; end
            if (!m_used[v][o]) begin
                m_used[v][o] = 1; f = 1; b = m_pb[v]; pg = o;
            end else begin
                if (!m_rv[v]) begin m_rv[v] = 1; m_rb[v] = m_next; m_next++; end
                if (m_wp[v] == P) e = 1;
                else begin
                    m_ro[v][m_wp[v]] = o; f = 1; b = m_rb[v]; pg = m_wp[v]; m_wp[v]++;
                end
            end
        end else begin
            bit hit = 0;
            if (m_rv[v]) begin
                for (int i = int'(m_wp[v]) - 1; i >= 0; i--) begin
                    if (!hit && m_ro[v][i] == o) begin
                        hit = 1; f = 1; b = m_rb[v]; pg = i;
                    end
                end
            end
            if (!hit && m_pv[v] && m_used[v][o]) begin f = 1; b = m_pb[v]; pg = o; end
        end
    endtask

    task automatic do_req(input bit w, input int unsigned a, input string tag);
        bit ef, ee; int unsigned eb, ep; int n = 0; bit saw_alloc = 0;
        model(w, a, ef, ee, eb, ep);
        while (!req_ready) @(negedge clk);
        req_write = w; req_laddr = 7'(a); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && n < 100) begin
            if (alloc_req) saw_alloc = 1;
            @(negedge clk); n++;
        end
        checks++;
        if (!rsp_valid) begin
            errors++;
            $display("FAIL %s R2 no response: got rsp_valid=0 expected 1 (addr %0h)", tag, a);
            return;
        end
        if (rsp_found !== ef || rsp_err !== ee || (ef && (rsp_blk !== 8'(eb) || rsp_page !== 3'(ep)))) begin
            errors++;
            $display("FAIL %s w=%0d addr=%0h: got found=%0d err=%0d blk=%0d page=%0d expected found=%0d err=%0d blk=%0d page=%0d",
                     tag, w, a, rsp_found, rsp_err, rsp_blk, rsp_page, ef, ee, eb, ep);
        end
        if (!w) begin
            checks++;
            if (saw_alloc) begin
                errors++;
                $display("FAIL R10 read raised alloc_req: got 1 expected 0 (addr %0h)", a);
            end
        end
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R2 response pulse longer than one cycle: got rsp_valid=%0d expected 0", rsp_valid);
        end
    endtask

    initial begin
        void'($urandom(32'd20240601));
        repeat (3) @(negedge clk);
        checks++;
        if (req_ready !== 1'b1 || rsp_valid !== 1'b0 || alloc_req !== 1'b0) begin
            errors++;
            $display("FAIL R11 reset outputs: got ready=%0d rsp_valid=%0d alloc_req=%0d expected 1 0 0",
                     req_ready, rsp_valid, alloc_req);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // directed corner cases on virtual block 9 (address 7'h4B = vbn 9, offset 3)
        do_req(0, 7'h4B, "R10 unwritten read");
        do_req(1, 7'h4B, "R1 R4 first write allocates primary");
        do_req(0, 7'h4B, "R9 read primary");
        do_req(1, 7'h4B, "R5 replacement page 0");
        do_req(1, 7'h49, "R3 unused primary page");
        do_req(1, 7'h49, "R6 replacement page 1");
        do_req(1, 7'h4B, "R6 replacement page 2");
        do_req(0, 7'h4B, "R8 newest copy");
        do_req(0, 7'h49, "R8 older copy below newer");
        do_req(0, 7'h4C, "R10 unwritten offset in mapped block");
        for (int k = 0; k < 5; k++) do_req(1, 7'h4B, "R6 fill replacement");
        do_req(1, 7'h4B, "R7 full replacement");
        do_req(1, 7'h49, "R7 full replacement again");
        do_req(0, 7'h4B, "R7 state unchanged after error");
        do_req(0, 7'h49, "R7 R8 scan past newer pages");

        // constrained random traffic on a few virtual blocks
        for (int k = 0; k < 400; k++) begin
            int unsigned v = $urandom % 5;
            int unsigned o = $urandom % P;
            bit w = ($urandom % 3) != 0;
            do_req(w, v * P + o, w ? "R3 R5 R6 R7 random write" : "R8 R9 R10 random read");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule